// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides the clock of a synthesiser loop by a programmed 16-bit ratio. It emits one single-cycle pulse per divided period, and that pulse feeds a phase comparator. The divider is built from three parts:

- a dual-modulus prescaler, modelled in logic, that divides by 16 or by 17;
- a 4-bit swallow counter that selects the prescaler modulus;
- a 12-bit main counter that sets the length of each period.

The prescaler divides by 17 until the swallow counter has run out, then by 16. When the main counter expires, both counters reload. The ratio is therefore 16*M + A, where M is the upper 12 bits of the divisor and A is the lower 4 bits.

Three divide modes are available. Direct mode bypasses the prescaler and divides by the upper 12 bits only. Pulse-swallow mode divides by the full 16-bit value. Half-rate swallow mode places a divide-by-two stage ahead of the prescaler, which doubles the ratio.

A new divisor or mode is taken only at the reload point, so a period is never cut short. A standby input stops counting. When standby is released, counting restarts from a fresh load.

Top module: `swallow_divider`

## Requirements
- R1: While rst_ni is low, pulse_o is 0. After rst_ni rises with standby_i low, the first rising edge loads the divisor. The first pulse then appears K cycles after that edge, where K is the ratio of the selected mode.
- R2: When mode_i[0] is 0 (direct), the period is div_i[15:4] cycles. div_i[3:0] and mode_i[1] have no effect. The legal range is 16 to 4095.
- R3: When mode_i is 2'b01 (pulse-swallow), the period is div_i cycles, equal to 16*div_i[15:4] + div_i[3:0]. The legal range is 528 to 65535.
- R4: When mode_i is 2'b11 (half-rate swallow), the period is 2*div_i cycles.
- R5: pulse_o is high for exactly one clock cycle in each period.
- R6: A change on div_i or mode_i does not alter the period in progress. It takes effect from the next pulse onward.
- R7: While standby_i is sampled high, counting stops and pulse_o stays 0. After standby_i falls, the first rising edge that samples it low reloads from div_i and mode_i. The first pulse follows K cycles after that edge.

Modulus details:
- In swallow modes, the prescaler divides by 17 for the first div_i[3:0] prescaler cycles of a period and by 16 for the rest.
- Each unit of div_i[3:0] therefore lengthens the period by exactly one prescaler input cycle.
- This is checked through the period in R3 and R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock to be divided |
| rst_ni | input | 1 | Active-low asynchronous reset |
| standby_i | input | 1 | Stops counting and holds the divider in reload |
| mode_i | input | 2 | Bit 0 selects pulse-swallow; bit 1 adds the divide-by-two stage when bit 0 is set |
| div_i | input | 16 | Divisor: bits 15:4 are the main count, bits 3:0 the swallow count |
| pulse_o | output | 1 | One-cycle pulse per divided period |

## Verification
The assertions take for granted that every divisor loaded lies in the legal range of its mode. This means the main count is never zero, and in swallow modes it exceeds the swallow count. Under that condition the swallow counter is always empty when the main counter expires, and pulses are never closer than 16 cycles.

The stimulus loads divisors only from those ranges:
- it sweeps direct ratios 16 to 47 with non-zero ignored bits, plus 4095;
- it sweeps every swallow count at the bottom of the swallow range, in both swallow modes;
- it uses one large swallow ratio.

Changes to div_i and mode_i are made directly after a pulse, so each change is seen by exactly one later reload.

// File: rtl/sd_pkg.sv
package sd_pkg;
  typedef struct packed {
    logic half;
    logic swallow;
  } sd_mode_t;
endpackage

// File: rtl/sd_half_stage.sv
module sd_half_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic half_i,
  output logic en_o
);
  logic ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ph_q <= 1'b0;
    else if (load_i) ph_q <= 1'b0;
    else if (half_i) ph_q <= ~ph_q;
  end

  // every cycle when the stage is off, every second cycle when on
  assign en_o = ~half_i | ph_q;
endmodule

// File: rtl/sd_dual_mod.sv
module sd_dual_mod #(
  parameter int unsigned SW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          bypass_i,
  input  logic          en_i,
  input  logic [SW-1:0] swallow_i,
  output logic          tick_o,
  output logic          sw_zero_o
);
  localparam int unsigned PW = SW + 1;
  localparam logic [PW-1:0] LAST_LO = PW'((1 << SW) - 1);
  localparam logic [PW-1:0] LAST_HI = PW'(1 << SW);

  logic [PW-1:0] ps_q;
  logic [SW-1:0] sw_q;
  logic          ps_wrap;

  assign sw_zero_o = (sw_q == '0);
  // modulus 2^SW+1 while swallow remains, 2^SW afterwards
  assign ps_wrap   = sw_zero_o ? (ps_q == LAST_LO) : (ps_q == LAST_HI);
  assign tick_o    = en_i & (bypass_i | ps_wrap);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ps_q <= '0;
      sw_q <= '0;
    end else if (load_i) begin
      ps_q <= '0;
      sw_q <= swallow_i;
    end else if (en_i && !bypass_i) begin
      if (ps_wrap) begin
        ps_q <= '0;
        if (!sw_zero_o) sw_q <= sw_q - SW'(1);
      end else begin
        ps_q <= ps_q + PW'(1);
      end
    end
  end
endmodule

// File: rtl/sd_main_cnt.sv
module sd_main_cnt #(
  parameter int unsigned MW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          tick_i,
  input  logic [MW-1:0] load_val_i,
  output logic          last_o
);
  logic [MW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_i) cnt_q <= cnt_q - MW'(1);
  end

  assign last_o = (cnt_q == MW'(1));
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import sd_pkg::*;
#(
  parameter int unsigned SWALLOW_W = 4,
  parameter int unsigned MAIN_W    = 12,
  parameter bit          HAS_HALF  = 1'b1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          standby_i,
  input  logic [1:0]                    mode_i,
  input  logic [SWALLOW_W+MAIN_W-1:0]   div_i,
  output logic                          pulse_o
);
  localparam int unsigned DIV_W = SWALLOW_W + MAIN_W;

  sd_mode_t mode_in, act_mode_q;
  logic run_q, cnt_en, load, en_raw, en_cnt, tick, main_last, wrap;
  logic sw_zero, swallow_on, pulse_q;
  logic [SWALLOW_W-1:0] sw_load;
  logic [MAIN_W-1:0]    main_load;

  assign mode_in    = sd_mode_t'(mode_i);
  assign swallow_on = act_mode_q.swallow;
  assign cnt_en     = run_q & ~standby_i;
  // direct mode drops the swallow field and uses bits above it as the count
  assign sw_load    = mode_in.swallow ? div_i[SWALLOW_W-1:0] : '0;
  assign main_load  = div_i[DIV_W-1:SWALLOW_W];
  assign en_cnt     = en_raw & cnt_en;
  assign wrap       = tick & main_last;
  assign load       = ~cnt_en | wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q      <= 1'b0;
      act_mode_q <= '0;
      pulse_q    <= 1'b0;
    end else begin
      run_q   <= ~standby_i;
      pulse_q <= wrap;
      if (load) act_mode_q <= mode_in;
    end
  end

  generate
    if (HAS_HALF) begin : g_half
      logic half_on;
      assign half_on = act_mode_q.half & act_mode_q.swallow;
      sd_half_stage u_half (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (load),
        .half_i (half_on),
        .en_o   (en_raw)
      );
    end else begin : g_nohalf
      assign en_raw = 1'b1;
    end
  endgenerate

  sd_dual_mod #(.SW(SWALLOW_W)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .bypass_i  (~swallow_on),
    .en_i      (en_cnt),
    .swallow_i (sw_load),
    .tick_o    (tick),
    .sw_zero_o (sw_zero)
  );

  sd_main_cnt #(.MW(MAIN_W)) u_main (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .tick_i     (tick),
    .load_val_i (main_load),
    .last_o     (main_last)
  );

  assign pulse_o = pulse_q;
endmodule

// File: rtl/sd_chk.sv
module sd_chk
  import sd_pkg::*;
(
  input logic     clk_i,
  input logic     rst_ni,
  input logic     standby_i,
  input logic     pulse_o,
  input logic     load_i,
  input logic     wrap_i,
  input logic     sw_zero_i,
  input logic     swallow_on_i,
  input sd_mode_t act_mode_i
);
  localparam logic [4:0] MIN_GAP = 5'd15;

  logic [4:0] gap_q;
  logic       seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (pulse_o)             gap_q <= '0;
      else if (gap_q != 5'd31) gap_q <= gap_q + 5'd1;
      if (standby_i)           seen_q <= 1'b0;
      else if (pulse_o)        seen_q <= 1'b1;
    end
  end

  // R5
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);

  // R7
  standby_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |=> !pulse_o);

  // R3
  swallow_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && swallow_on_i) |-> sw_zero_i);

  // R6
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(act_mode_i));

  // R2
  min_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o && seen_q) |-> (gap_q >= MIN_GAP));
endmodule

bind swallow_divider sd_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .standby_i    (standby_i),
  .pulse_o      (pulse_o),
  .load_i       (load),
  .wrap_i       (wrap),
  .sw_zero_i    (sw_zero),
  .swallow_on_i (swallow_on),
  .act_mode_i   (act_mode_q)
);

// File: tb/sim_swallow_divider.sv
module sim_swallow_divider;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 190000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        standby_i = 1'b0;
  logic [1:0]  mode_i = 2'b01;
  logic [15:0] div_i = 16'd528;
  logic        pulse_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  swallow_divider u0 (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .standby_i (standby_i),
    .mode_i    (mode_i),
    .div_i     (div_i),
    .pulse_o   (pulse_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_CYCLES) begin
      errors++;
      $display("FAIL watchdog (all) actual %0d expected below %0d", cyc, WD_CYCLES);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int ratio(input logic [1:0] m, input logic [15:0] d);
    if (!m[0])     return int'(d[15:4]);
    else if (m[1]) return 2 * int'(d);
    else           return int'(d);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // counts negedges until pulse_o is seen high
  task automatic wait_pulse(input int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!pulse_o && n < limit);
  endtask

  task automatic run_case(input logic [1:0] m, input logic [15:0] d, input string req);
    int k, lat, per;
    k = ratio(m, d);
    @(negedge clk);
    standby_i = 1'b1;
    mode_i    = m;
    div_i     = d;
    repeat (2) @(negedge clk);
    standby_i = 1'b0;
    wait_pulse(k + 40, lat);
    chk(lat - 1 == k, {req, " first pulse"}, lat - 1, k);
    wait_pulse(k + 40, per);
    chk(per == k, {req, " period"}, per, k);
  endtask

  initial begin
    int n, cnt;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(pulse_o == 1'b0, "R1 reset pulse", int'(pulse_o), 0);
    rst_ni = 1'b1;
    wait_pulse(600, n);
    chk(n - 1 == 528, "R1 first pulse after reset", n - 1, 528);
    @(negedge clk);
    // R5: pulse lasts one cycle
    chk(pulse_o == 1'b0, "R5 pulse width", int'(pulse_o), 0);

    // R2: direct mode, low nibble and mode bit 1 ignored
    for (int m = 16; m < 48; m++) begin
      run_case((m % 2 == 0) ? 2'b00 : 2'b10, {12'(m), 4'(m ^ 5)}, "R2");
    end
    run_case(2'b00, 16'hFFFF, "R2 max");

    // R3: pulse-swallow, every swallow count
    for (int d = 528; d < 560; d++) begin
      run_case(2'b01, 16'(d), "R3");
    end
    run_case(2'b01, 16'd10847, "R3 large");

    // R4: half-rate swallow
    for (int d = 528; d < 544; d++) begin
      run_case(2'b11, 16'(d), "R4");
    end

    // R6: changes take effect one period later
    run_case(2'b01, 16'd600, "R6 setup");
    div_i = 16'd777;
    wait_pulse(900, n);
    chk(n == 600, "R6 old divisor kept", n, 600);
    mode_i = 2'b00;
    div_i  = {12'd50, 4'h3};
    wait_pulse(900, n);
    chk(n == 777, "R6 new divisor used", n, 777);
    mode_i = 2'b11;
    div_i  = 16'd530;
    wait_pulse(900, n);
    chk(n == 50, "R6 direct after swallow", n, 50);
    wait_pulse(1200, n);
    chk(n == 1060, "R6 half after direct", n, 1060);
    @(negedge clk);
    chk(pulse_o == 1'b0, "R5 pulse width half", int'(pulse_o), 0);

    // R7: standby mid-period halts, release restarts from a fresh load
    mode_i = 2'b01;
    div_i  = 16'd600;
    wait_pulse(1200, n);
    wait_pulse(700, n);
    repeat (100) @(negedge clk);
    standby_i = 1'b1;
    cnt = 0;
    for (int i = 0; i < 1300; i++) begin
      @(negedge clk);
      if (pulse_o) cnt++;
    end
    chk(cnt == 0, "R7 no pulse in standby", cnt, 0);
    standby_i = 1'b0;
    wait_pulse(700, n);
    chk(n - 1 == 600, "R7 restart latency", n - 1, 600);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule